// File: doc/BRIEF.md
# Low-Voltage Detect Control Register

This block is the software-visible byte register of a supply low-voltage detector. A raw comparator output enters asynchronously. It passes through a synchroniser and is then captured into a sticky detect flag. Software reads the flag over a one-address byte port. It clears the flag by writing a separate acknowledge bit. From the flag and its enables, the block drives an interrupt request, a system reset request and a bandgap buffer enable.

Two configuration bits, the reset enable and the detect enable, lock after the first bus write following reset. A stop-mode input restricts capture: while it is high, events are taken only if the stop enable is also set. The comparator, the trip-level selection and the reset controller that acts on the request sit outside this block.

Top module: `lvdet_csr`

## Requirements
- R1: After reset the register reads 0x1C, with reset enable (bit 4), stop enable (bit 3) and detect enable (bit 2) at 1 and all other bits at 0. irq_o and rst_req_o are 0.
- R2: The raw input passes two synchronising flops. The flag (bit 7) reads 1 on the third rising edge after lv_raw_i goes high, and not before.
- R3: While detect enable is 0, the flag is never set.
- R4: Writing 1 to bit 6 clears the flag. Bits 6 and 1 always read 0, whatever is written to them.
- R5: If a captured event and an acknowledge write fall in the same cycle, the flag stays 1.
- R6: Bits 4 and 2 take the value of the first write after reset. Later writes to them are ignored until the next reset.
- R7: Interrupt enable (bit 5), stop enable (bit 3) and bandgap enable (bit 0) follow every write. bg_buf_en_o equals bit 0.
- R8: irq_o is 1 exactly when interrupt enable and the flag are both 1.
- R9: rst_req_o is 1 exactly when reset enable, detect enable and the flag are all 1.
- R10: While stop_i is 1, events are captured only if both stop enable and detect enable are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Write strobe for the register |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data |
| lv_raw_i | input | 1 | Raw comparator output, asynchronous |
| stop_i | input | 1 | Stop-mode indicator |
| irq_o | output | 1 | Interrupt request |
| rst_req_o | output | 1 | System reset request |
| bg_buf_en_o | output | 1 | Bandgap buffer enable |

## Verification
The detect path is tested with several patterns. A plain rising input with defaults checks the three-edge capture latency. A comparator held high while the acknowledge is written separates correct event priority from a clear-first design. Stop mode is tested with the stop enable cleared, which separates correct stop gating from ungated capture. Releasing stop then confirms that the already-synchronised level is captured one edge later. Two write orders for the lock bits, first 0 then 1 and first 1 then 0, separate true write-once behaviour from one-way sticky behaviour or plain writable bits.

// File: rtl/lvdet_pkg.sv
package lvdet_pkg;
  localparam int REG_W   = 8;
  localparam int B_FLAG  = 7;
  localparam int B_ACK   = 6;
  localparam int B_IE    = 5;
  localparam int B_RE    = 4;
  localparam int B_SE    = 3;
  localparam int B_DE    = 2;
  localparam int B_RSVD  = 1;
  localparam int B_BG    = 0;
  localparam int N_WO    = 2;
  localparam int WO_POS [N_WO] = '{B_RE, B_DE};
  localparam logic [REG_W-1:0] RST_VAL = 8'h1C;
endpackage

// File: rtl/lvdet_sync.sv
module lvdet_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else if (STAGES == 1) sr_q <= d_i;
    else sr_q <= {sr_q[STAGES-2:0], d_i};
  end
  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/lvdet_wo_bit.sv
module lvdet_wo_bit #(
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic we_i,
  input  logic d_i,
  output logic q_o
);
  logic lock_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q <= 1'b0;
      q_o    <= RST_VAL;
    end else if (we_i) begin
      lock_q <= 1'b1;
      if (!lock_q) q_o <= d_i;
    end
  end
endmodule

// File: rtl/lvdet_flag.sv
module lvdet_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  // set wins over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;
    else if (clr_i) flag_o <= 1'b0;
  end
endmodule

// File: rtl/lvdet_csr.sv
module lvdet_csr
  import lvdet_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bus_we_i,
  input  logic [REG_W-1:0] bus_wdata_i,
  output logic [REG_W-1:0] bus_rdata_o,
  input  logic             lv_raw_i,
  input  logic             stop_i,
  output logic             irq_o,
  output logic             rst_req_o,
  output logic             bg_buf_en_o
);
  logic            lv_sync;
  logic            cap_en;
  logic            flag_q;
  logic            ie_q, se_q, bg_q;
  logic [N_WO-1:0] wo_q;
  logic            re_q, de_q;

  lvdet_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (lv_raw_i),
    .q_o   (lv_sync)
  );

  for (genvar g = 0; g < N_WO; g++) begin : g_wo
    lvdet_wo_bit #(.RST_VAL(RST_VAL[WO_POS[g]])) u_wo (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .we_i  (bus_we_i),
      .d_i   (bus_wdata_i[WO_POS[g]]),
      .q_o   (wo_q[g])
    );
  end
  assign re_q = wo_q[0];
  assign de_q = wo_q[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ie_q <= RST_VAL[B_IE];
      se_q <= RST_VAL[B_SE];
      bg_q <= RST_VAL[B_BG];
    end else if (bus_we_i) begin
      ie_q <= bus_wdata_i[B_IE];
      se_q <= bus_wdata_i[B_SE];
      bg_q <= bus_wdata_i[B_BG];
    end
  end

  assign cap_en = de_q & (~stop_i | se_q);

  lvdet_flag u_flag (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (lv_sync & cap_en),
    .clr_i (bus_we_i & bus_wdata_i[B_ACK]),
    .flag_o(flag_q)
  );

  always_comb begin
    bus_rdata_o         = '0;
    bus_rdata_o[B_FLAG] = flag_q;
    bus_rdata_o[B_IE]   = ie_q;
    bus_rdata_o[B_RE]   = re_q;
    bus_rdata_o[B_SE]   = se_q;
    bus_rdata_o[B_DE]   = de_q;
    bus_rdata_o[B_BG]   = bg_q;
  end

  assign irq_o       = ie_q & flag_q;
  assign rst_req_o   = re_q & de_q & flag_q;
  assign bg_buf_en_o = bg_q;
endmodule

// File: rtl/lvdet_csr_chk.sv
module lvdet_csr_chk
  import lvdet_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             bus_we_i,
  input logic [REG_W-1:0] bus_wdata_i,
  input logic [REG_W-1:0] bus_rdata_o,
  input logic             irq_o,
  input logic             rst_req_o,
  input logic             bg_buf_en_o
);
  logic seen_wr_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       seen_wr_q <= 1'b0;
    else if (bus_we_i) seen_wr_q <= 1'b1;
  end

  // R4
  rsvd_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_rdata_o[B_ACK] == 1'b0 && bus_rdata_o[B_RSVD] == 1'b0);

  // R6
  re_locked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_i && seen_wr_q) |=> $stable(bus_rdata_o[B_RE]));

  // R6
  de_locked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_i && seen_wr_q) |=> $stable(bus_rdata_o[B_DE]));

  // R3
  no_cap_disabled_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bus_rdata_o[B_DE] && !bus_rdata_o[B_FLAG]) |=> !bus_rdata_o[B_FLAG]);

  // R8
  irq_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (bus_rdata_o[B_IE] & bus_rdata_o[B_FLAG]));

  // R9
  rst_req_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o == (bus_rdata_o[B_RE] & bus_rdata_o[B_DE] & bus_rdata_o[B_FLAG]));

  // R7
  bg_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bg_buf_en_o == bus_rdata_o[B_BG]);
endmodule

bind lvdet_csr lvdet_csr_chk u_chk (.*);

// File: tb/sim_lvdet_csr.sv
`timescale 1ns/1ps
module sim_lvdet_csr;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       bus_we_i = 1'b0;
  logic [7:0] bus_wdata_i = 8'h00;
  logic [7:0] bus_rdata_o;
  logic       lv_raw_i = 1'b0;
  logic       stop_i = 1'b0;
  logic       irq_o, rst_req_o, bg_buf_en_o;
  int         checks = 0;
  int         errors = 0;
  bit         done = 1'b0;

  always #5 clk_i = ~clk_i;

  lvdet_csr u0 (.*);

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0; bus_we_i = 1'b0; lv_raw_i = 1'b0; stop_i = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic wr(logic [7:0] d);
    @(negedge clk_i);
    bus_we_i = 1'b1; bus_wdata_i = d;
    @(negedge clk_i);
    bus_we_i = 1'b0;
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic t_reset();
    do_reset();
    cyc(1);
    chk("R1 rdata", bus_rdata_o, 8'h1C);
    chk("R1 irq/rst_req", {6'b0, irq_o, rst_req_o}, 8'h00);
  endtask

  task automatic t_detect();
    do_reset();
    @(negedge clk_i); lv_raw_i = 1'b1;
    cyc(2);
    chk("R2 not yet", bus_rdata_o[7], 1'b0);
    cyc(1);
    chk("R2 flag", bus_rdata_o[7], 1'b1);
    chk("R9 rst_req", rst_req_o, 1'b1);
    chk("R8 irq off", irq_o, 1'b0);
    wr(8'h3C);
    chk("R8 irq on", irq_o, 1'b1);
    lv_raw_i = 1'b0;
    cyc(3);
    wr(8'h7C);
    chk("R4 ack", bus_rdata_o, 8'h3C);
    chk("R8 irq cleared", irq_o, 1'b0);
  endtask

  task automatic t_reserved();
    do_reset();
    wr(8'h7F);
    chk("R4 R7 reserved", bus_rdata_o, 8'h3D);
    chk("R7 bg pin", bg_buf_en_o, 1'b1);
    wr(8'h3C);
    chk("R7 bg off", bg_buf_en_o, 1'b0);
  endtask

  task automatic t_once_zero();
    do_reset();
    wr(8'h00);
    chk("R6 first write 0", bus_rdata_o, 8'h00);
    wr(8'h1C);
    chk("R6 R7 later write", bus_rdata_o, 8'h08);
    lv_raw_i = 1'b1;
    cyc(5);
    chk("R3 no capture", bus_rdata_o[7], 1'b0);
    chk("R9 no rst_req", rst_req_o, 1'b0);
    lv_raw_i = 1'b0;
  endtask

  task automatic t_once_one();
    do_reset();
    wr(8'h1C);
    wr(8'h00);
    chk("R6 kept", bus_rdata_o, 8'h14);
    wr(8'h00);
    chk("R6 kept again", bus_rdata_o, 8'h14);
  endtask

  task automatic t_stop();
    do_reset();
    stop_i = 1'b1;
    @(negedge clk_i); lv_raw_i = 1'b1;
    cyc(3);
    chk("R10 stop enabled", bus_rdata_o[7], 1'b1);
    do_reset();
    wr(8'h14);
    stop_i = 1'b1;
    lv_raw_i = 1'b1;
    cyc(5);
    chk("R10 stop gated", bus_rdata_o[7], 1'b0);
    stop_i = 1'b0;
    cyc(1);
    chk("R10 after stop", bus_rdata_o[7], 1'b1);
    lv_raw_i = 1'b0;
  endtask

  task automatic t_prio();
    do_reset();
    lv_raw_i = 1'b1;
    cyc(4);
    chk("R2 held", bus_rdata_o[7], 1'b1);
    wr(8'h5C);
    chk("R5 set wins", bus_rdata_o[7], 1'b1);
    lv_raw_i = 1'b0;
    cyc(3);
    wr(8'h5C);
    chk("R4 cleared", bus_rdata_o, 8'h1C);
  endtask

  initial begin
    t_reset();
    t_detect();
    t_reserved();
    t_once_zero();
    t_once_one();
    t_stop();
    t_prio();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule